// File: doc/BRIEF.md
# Bidirectional Pin Boundary-Scan Segment

This block is the slice of a boundary-scan register that serves one bidirectional I/O pad with a pull-up. It sits between the core port logic and the pad driver. In normal operation the core's direction, output value and computed pull-up pass straight through to the pad. In external-test mode the pad is driven from a set of held update stages. The scan data-register controls (shift select, a capture/shift clock enable and an update enable) come from a TAP controller that is not part of this block.

Three stages form the segment. The first stage holds the pull-up enable. The second holds the drive direction. The third holds the drive value, and on capture it also samples the pad's input level. So the three pad signals share two shift positions, and the pull-up gets a cell of its own. Serial data enters at the pull-up stage and leaves from the data stage. The level seen at the pad goes back to the core with no synchronising register.

Top module: `bscan_bidir_pin`

## Requirements
- R1: A synchronous active-low reset clears all three capture stages and all three update stages to 0. After reset, even with external test selected, the pad is an input with no pull-up, and the serial output reads 0.
- R2: When `tdr_clock`=1 and `tdr_shift`=1 on a clock edge, the stages advance one position in this order: `scan_in` → pull-up stage → direction stage → data stage → `scan_out`. `scan_out` is the data stage's capture bit, so a bit appears at `scan_out` after the third such edge.
- R3: When `tdr_clock`=0, no capture stage changes, whatever the values of `tdr_shift` and `scan_in`.
- R4: When `tdr_clock`=1 and `tdr_shift`=0, each stage captures a parallel value. The pull-up stage takes the functional pull-up enable, the direction stage takes `core_oe`, and the data stage takes `pin_in`.
- R5: An update stage loads its capture stage's value only on an edge with `tdr_update`=1. At all other times it holds.
- R6: When `ext_test`=1, `pin_oe`, `pin_out` and `pin_pu` come from the direction, data and pull-up update stages.
- R7: When `ext_test`=0, `pin_oe`=`core_oe` and `pin_out`=`core_out`, and `pin_pu` = (NOT `core_pud`) AND (NOT `core_oe`) AND `core_out`.
- R8: `core_in` follows `pin_in` combinationally, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan and update clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tdr_shift | input | 1 | 1 selects shift, 0 selects capture |
| tdr_clock | input | 1 | Capture/shift enable for the current edge |
| tdr_update | input | 1 | Update-stage load enable |
| ext_test | input | 1 | 1 drives the pad from the update stages |
| scan_in | input | 1 | Serial data from the previous segment |
| scan_out | output | 1 | Serial data to the next segment |
| core_oe | input | 1 | Core drive direction (1 = output) |
| core_out | input | 1 | Core drive value |
| core_pud | input | 1 | Core global pull-up disable |
| core_in | output | 1 | Pad level returned to the core |
| pin_oe | output | 1 | Pad driver enable |
| pin_out | output | 1 | Pad drive value |
| pin_pu | output | 1 | Pad pull-up enable |
| pin_in | input | 1 | Level observed at the pad |

## Verification
The hardest case to reach is a capture that reads a pad pulled high while nothing drives it. For that, the functional pull-up term must be true (direction input, port value 1, pull-up not disabled), external test must be off, and the bench's pad model must release its own driver. Only then does the data stage capture 1 from the pull-up alone. The bench sets up exactly that state and then shifts the three captured bits out to see each stage separately. Loading the update stages in a known arrangement takes a full three-edge shift followed by a separate update edge. A second shift without an update then shows that the pads do not move.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
    localparam int BSC_CELLS = 3;
    localparam int BSC_IDX_W = $clog2(BSC_CELLS);

    // Stage positions along the serial path (scan_in side first)
    localparam int CELL_PULL = 0;
    localparam int CELL_DIR  = 1;
    localparam int CELL_DATA = BSC_CELLS - 1;

    typedef struct packed {
        logic cap;
        logic upd;
    } bscan_cell_t;
endpackage

// File: rtl/bscan_stage.sv
module bscan_stage
    import bscan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clock_en,
    input  logic shift_sel,
    input  logic update_en,
    input  logic serial_in,
    input  logic parallel_in,
    output logic cap_bit,
    output logic upd_bit
);
    bscan_cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (clock_en)
            cell_d.cap = shift_sel ? serial_in : parallel_in;
        if (update_en)
            cell_d.upd = cell_q.cap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cell_q <= '0;
        else
            cell_q <= cell_d;
    end

    assign cap_bit = cell_q.cap;
    assign upd_bit = cell_q.upd;
endmodule

// File: rtl/bscan_pin_mux.sv
module bscan_pin_mux
    import bscan_pkg::*;
(
    input  logic                 ext_test,
    input  logic [BSC_CELLS-1:0] upd_vec,
    input  logic                 core_oe,
    input  logic                 core_out,
    input  logic                 core_pud,
    output logic                 func_pu,
    output logic                 pin_oe,
    output logic                 pin_out,
    output logic                 pin_pu
);
    always_comb begin
        func_pu = !core_pud && !core_oe && core_out;
        if (ext_test) begin
            pin_oe  = upd_vec[CELL_DIR];
            pin_out = upd_vec[CELL_DATA];
            pin_pu  = upd_vec[CELL_PULL];
        end else begin
            pin_oe  = core_oe;
            pin_out = core_out;
            pin_pu  = func_pu;
        end
    end
endmodule

// File: rtl/bscan_bidir_pin.sv
module bscan_bidir_pin
    import bscan_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tdr_shift,
    input  logic tdr_clock,
    input  logic tdr_update,
    input  logic ext_test,
    input  logic scan_in,
    output logic scan_out,
    input  logic core_oe,
    input  logic core_out,
    input  logic core_pud,
    output logic core_in,
    output logic pin_oe,
    output logic pin_out,
    output logic pin_pu,
    input  logic pin_in
);
    logic [BSC_CELLS-1:0] cap_q;
    logic [BSC_CELLS-1:0] upd_q;
    logic [BSC_CELLS-1:0] par_in;
    logic [BSC_CELLS-1:0] ser_in;
    logic                 func_pu;

    always_comb begin
        par_in            = '0;
        par_in[CELL_PULL] = func_pu;
        par_in[CELL_DIR]  = core_oe;
        par_in[CELL_DATA] = pin_in;
    end

    genvar gi;
    generate
        for (gi = 0; gi < BSC_CELLS; gi++) begin : g_cell
            if (gi == 0) begin : g_head
                assign ser_in[gi] = scan_in;
            end else begin : g_link
                assign ser_in[gi] = cap_q[gi-1];
            end
            bscan_stage u_stage (
                .clk        (clk),
                .rst_n      (rst_n),
                .clock_en   (tdr_clock),
                .shift_sel  (tdr_shift),
                .update_en  (tdr_update),
                .serial_in  (ser_in[gi]),
                .parallel_in(par_in[gi]),
                .cap_bit    (cap_q[gi]),
                .upd_bit    (upd_q[gi])
            );
        end
    endgenerate

    bscan_pin_mux u_mux (
        .ext_test(ext_test),
        .upd_vec (upd_q),
        .core_oe (core_oe),
        .core_out(core_out),
        .core_pud(core_pud),
        .func_pu (func_pu),
        .pin_oe  (pin_oe),
        .pin_out (pin_out),
        .pin_pu  (pin_pu)
    );

    assign scan_out = cap_q[CELL_DATA];
    assign core_in  = pin_in;
endmodule

// File: rtl/bscan_bidir_pin_chk.sv
module bscan_bidir_pin_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tdr_shift,
    input logic       tdr_clock,
    input logic       tdr_update,
    input logic       ext_test,
    input logic       pin_in,
    input logic       scan_out,
    input logic       core_oe,
    input logic       core_out,
    input logic       core_pud,
    input logic       pin_out,
    input logic       pin_pu,
    input logic [2:0] cap_q,
    input logic [2:0] upd_q
);
    AST_SHIFT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (tdr_clock && tdr_shift) |=> (scan_out == $past(cap_q[1]))); // R2

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tdr_clock |=> $stable(cap_q)); // R3

    AST_CAPTURE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tdr_clock && !tdr_shift) |=> (scan_out == $past(pin_in))); // R4

    AST_UPDATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tdr_update |=> $stable(upd_q)); // R5

    AST_EXTEST_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (tdr_update && ext_test) |=> (!ext_test || pin_out == $past(cap_q[2]))); // R6

    AST_FUNC_PULLUP: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_test |-> (pin_pu == (!core_pud && !core_oe && core_out))); // R7
endmodule

bind bscan_bidir_pin bscan_bidir_pin_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tdr_shift (tdr_shift),
    .tdr_clock (tdr_clock),
    .tdr_update(tdr_update),
    .ext_test  (ext_test),
    .pin_in    (pin_in),
    .scan_out  (scan_out),
    .core_oe   (core_oe),
    .core_out  (core_out),
    .core_pud  (core_pud),
    .pin_out   (pin_out),
    .pin_pu    (pin_pu),
    .cap_q     (cap_q),
    .upd_q     (upd_q)
);

// File: tb/test_bscan_bidir_pin.sv
`timescale 1ns/1ps
module test_bscan_bidir_pin;
    logic clk = 1'b0;
    logic rst_n, tdr_shift, tdr_clock, tdr_update, ext_test, scan_in;
    logic core_oe, core_out, core_pud;
    logic scan_out, core_in, pin_oe, pin_out, pin_pu, pin_in;
    logic ext_en, ext_val;
    int   n_checks = 0;
    int   n_fails  = 0;

    always #2 clk = ~clk;

    // Pad model: own driver, else external driver, else pull-up, else low
    assign pin_in = pin_oe ? pin_out : (ext_en ? ext_val : (pin_pu ? 1'b1 : 1'b0));

    bscan_bidir_pin i_bscan_bidir_pin (
        .clk(clk), .rst_n(rst_n), .tdr_shift(tdr_shift), .tdr_clock(tdr_clock),
        .tdr_update(tdr_update), .ext_test(ext_test), .scan_in(scan_in),
        .scan_out(scan_out), .core_oe(core_oe), .core_out(core_out),
        .core_pud(core_pud), .core_in(core_in), .pin_oe(pin_oe),
        .pin_out(pin_out), .pin_pu(pin_pu), .pin_in(pin_in)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        tdr_clock = 0; tdr_shift = 0; tdr_update = 0;
    endtask

    task automatic shift_bit(input logic b);
        tdr_clock = 1; tdr_shift = 1; scan_in = b;
        step();
        idle();
    endtask

    task automatic capture();
        tdr_clock = 1; tdr_shift = 0;
        step();
        idle();
    endtask

    task automatic update();
        tdr_update = 1;
        step();
        idle();
    endtask

    task automatic t_reset();
        rst_n = 0; idle(); ext_test = 1; scan_in = 1;
        core_oe = 1; core_out = 1; core_pud = 0; ext_en = 0; ext_val = 0;
        step(); step();
        rst_n = 1;
        step();
        chk(pin_oe,   1'b0, "R1", "pin_oe after reset");
        chk(pin_pu,   1'b0, "R1", "pin_pu after reset");
        chk(pin_out,  1'b0, "R1", "pin_out after reset");
        chk(scan_out, 1'b0, "R1", "scan_out after reset");
        ext_test = 0;
    endtask

    task automatic t_normal();
        ext_test = 0;
        for (int k = 0; k < 8; k++) begin
            {core_pud, core_oe, core_out} = 3'(k);
            #1;
            chk(pin_oe,  core_oe,  "R7", "pin_oe passthrough");
            chk(pin_out, core_out, "R7", "pin_out passthrough");
            chk(pin_pu,  (!core_pud && !core_oe && core_out), "R7", "functional pull-up");
        end
    endtask

    task automatic t_nosync();
        ext_test = 0; core_oe = 0; core_out = 0; core_pud = 1; ext_en = 1;
        ext_val = 1; #1;
        chk(core_in, 1'b1, "R8", "core_in follows pad high");
        ext_val = 0; #1;
        chk(core_in, 1'b0, "R8", "core_in follows pad low");
        ext_en = 0;
        @(negedge clk);
    endtask

    task automatic t_shift();
        logic [5:0] pat;
        pat = 6'b001101;   // pat[0] shifted first
        // Chain holds zeros from reset
        for (int k = 1; k <= 6; k++) begin
            shift_bit(pat[k-1]);
            chk(scan_out, (k < 3) ? 1'b0 : pat[k-3], "R2", $sformatf("scan_out after shift edge %0d", k));
        end
    endtask

    task automatic t_gate();
        logic held;
        held = scan_out;
        for (int k = 0; k < 3; k++) begin
            tdr_clock = 0; tdr_shift = 1; scan_in = ~held;
            step();
            chk(scan_out, held, "R3", "no change without clock enable");
        end
        idle();
    endtask

    task automatic t_extest();
        core_oe = 0; core_out = 1; core_pud = 1; ext_en = 0;
        // Load data=0, dir=1, pull=1 (first shifted bit ends in data stage)
        shift_bit(0); shift_bit(1); shift_bit(1);
        update();
        ext_test = 1; #1;
        chk(pin_oe,  1'b1, "R6", "pin_oe from update stage");
        chk(pin_out, 1'b0, "R6", "pin_out from update stage");
        chk(pin_pu,  1'b1, "R6", "pin_pu from update stage");
        // New chain contents without update: pads hold
        shift_bit(1); shift_bit(0); shift_bit(0);
        chk(pin_oe,  1'b1, "R5", "pin_oe held without update");
        chk(pin_out, 1'b0, "R5", "pin_out held without update");
        chk(pin_pu,  1'b1, "R5", "pin_pu held without update");
        update(); #1;
        chk(pin_oe,  1'b0, "R5", "pin_oe after update");
        chk(pin_out, 1'b1, "R5", "pin_out after update");
        chk(pin_pu,  1'b0, "R5", "pin_pu after update");
        ext_test = 0;
    endtask

    task automatic t_capture(input logic oe, input logic out, input logic pud,
                             input logic een, input logic evl,
                             input logic e_data, input logic e_dir, input logic e_pull);
        ext_test = 0; core_oe = oe; core_out = out; core_pud = pud;
        ext_en = een; ext_val = evl;
        capture();
        chk(scan_out, e_data, "R4", "data stage captured pad level");
        shift_bit(0);
        chk(scan_out, e_dir, "R4", "direction stage captured core_oe");
        shift_bit(0);
        chk(scan_out, e_pull, "R4", "pull-up stage captured functional pull-up");
        ext_en = 0;
    endtask

    initial begin
        t_reset();
        t_normal();
        t_nosync();
        t_shift();
        t_gate();
        t_extest();
        // Undriven pad held high by the pull-up alone
        t_capture(0, 1, 0, 0, 0, 1, 0, 1);
        // Pad driven low externally, no pull-up
        t_capture(0, 0, 0, 1, 0, 0, 0, 0);
        // Core driving high
        t_capture(1, 1, 0, 0, 0, 1, 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule